// File: doc/BRIEF.md
# Calendar Clock with Alarm and Interval Timer

This block keeps wall-clock time and date from a one-pulse-per-second tick. It holds seconds, minutes, hours, day, month, a two-digit year and a day-of-week index. It handles month lengths and leap years by itself. Software reaches every field through a simple write port and a combinational read port. Any field can be rewritten while counting continues: there is no stop bit and no reload sequence.

Two interrupt sources sit beside the calendar. The alarm compares minute, hour, day, month and year against programmed values. Each of these five fields has its own enable bit, so the alarm can match on a single field or on any combination. The interval timer counts ticks down from a programmed period. It either fires once and stops, or reloads and fires at every period. Both flags stay set until software clears them.

Register map (8-bit data, BCD for all time fields): 0 seconds, 1 minutes, 2 hours, 3 day, 4 month, 5 year, 6 weekday (binary 0..6), 7 alarm minute, 8 alarm hour, 9 alarm day, 10 alarm month, 11 alarm year, 12 alarm enables, 13 timer control, 14 timer period (binary ticks), 15 flags.

Top module: `rtc_calendar_top`

## Requirements
- R1: On each tick, seconds advance in BCD. Seconds 59 wrap to 00 and carry into minutes. Minutes 59 wrap to 00 and carry into hours. Hours 23 wrap to 00 and carry into the day. Without a tick or a write, no time field changes.
- R2: The day carries into the month when it reaches the month length: 31 for months 01, 03, 05, 07, 08, 10 and 12; 30 for months 04, 06, 09 and 11; 28 for February in non-leap years. The day then restarts at 01.
- R3: A year whose decimal value is divisible by 4 is a leap year, and this includes year 00. In a leap year, February has 29 days.
- R4: Month 12 wraps to 01 and carries into the year. Year 99 wraps to 00.
- R5: The weekday (register 6, binary 0..6) advances by one each time the day advances, and 6 wraps to 0.
- R6: A write to a time field leaves counting running. If the write arrives in the same cycle as a tick, the written field takes the written value. The other fields still advance, with carries taken from their values before the write.
- R7: A stored day larger than the current month's length rolls to day 01 of the next month at the next day increment.
- R8: Register 12 holds the alarm enables: bit0 minute, bit1 hour, bit2 day, bit3 month, bit4 year. The alarm flag (register 15 bit0) is set on a tick that takes seconds to 00, when at least one field is enabled and every enabled field equals the new time. The flag stays set until software writes 1 to register 15 bit0. A new set in the same cycle wins over the clear.
- R9: Register 13 holds the timer control: bit0 is the run enable and bit1 selects periodic mode. Writing register 13 with bit0=1 and bit1=0 and a nonzero period P sets the timer flag (register 15 bit1) on the P-th following tick, after which the timer stops. Writing 1 to register 15 bit1 clears that flag.
- R10: With bit1=1 in register 13, the timer reloads P after firing and sets the flag at every P-th tick.
- R11: After reset, the time reads 00:00:00 on day 01, month 01, year 00, weekday 0. The flags, the alarm enables and the timer control read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle pulse once per second |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Write register index |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | ADDR_W | Read register index |
| rd_data_o | output | 8 | Read data, combinational from rd_addr_i |
| alarm_irq_o | output | 1 | Sticky alarm flag |
| timer_irq_o | output | 1 | Sticky interval-timer flag |

## Verification
The assertions take for granted that the tick is a single-cycle pulse and that each written time field holds a valid BCD value. A day larger than the month length is the only out-of-range value they allow for. The wrap and weekday properties each exclude a write to the field they watch, because a write in the same cycle wins over the counter. The bench loads every field by register writes while the tick is low. It writes only legal BCD digits, and its one deliberately invalid date is a day that is too large for its month. It overlaps a tick with a write only in the directed test for write priority.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam int unsigned A_SEC     = 0;
  localparam int unsigned A_MIN     = 1;
  localparam int unsigned A_HOUR    = 2;
  localparam int unsigned A_DAY     = 3;
  localparam int unsigned A_MON     = 4;
  localparam int unsigned A_YEAR    = 5;
  localparam int unsigned A_WDAY    = 6;
  localparam int unsigned A_AL_MIN  = 7;
  localparam int unsigned A_AL_HOUR = 8;
  localparam int unsigned A_AL_DAY  = 9;
  localparam int unsigned A_AL_MON  = 10;
  localparam int unsigned A_AL_YEAR = 11;
  localparam int unsigned A_AL_EN   = 12;
  localparam int unsigned A_TM_CTRL = 13;
  localparam int unsigned A_TM_PER  = 14;
  localparam int unsigned A_FLAGS   = 15;

  localparam int unsigned WDAY_W = 3;

  typedef struct packed {
    logic [7:0]        sec;
    logic [7:0]        min;
    logic [7:0]        hour;
    logic [7:0]        day;
    logic [7:0]        mon;
    logic [7:0]        year;
    logic [WDAY_W-1:0] wday;
  } cal_t;

  // two BCD digits to binary
  function automatic logic [7:0] bcd2bin(input logic [7:0] b);
    return ({4'd0, b[7:4]} * 8'd10) + {4'd0, b[3:0]};
  endfunction

  // BCD increment without range wrap
  function automatic logic [7:0] bcd_inc(input logic [7:0] b);
    if (b[3:0] >= 4'd9) return {b[7:4] + 4'd1, 4'd0};
    return b + 8'd1;
  endfunction

  function automatic logic leap_year(input logic [7:0] y);
    logic [7:0] v;
    v = bcd2bin(y);
    return v[1:0] == 2'b00;
  endfunction

  // month length in binary days
  function automatic logic [7:0] month_len(input logic [7:0] m, input logic [7:0] y);
    case (bcd2bin(m))
      8'd2:                     return leap_year(y) ? 8'd29 : 8'd28;
      8'd4, 8'd6, 8'd9, 8'd11:  return 8'd30;
      default:                  return 8'd31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_chain.sv
module rtc_chain
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output cal_t              cur,
  output cal_t              nxt,
  output logic              sec_zero_evt
);

  cal_t t_q, n;
  logic sec_wrap, min_wrap, hour_wrap, day_wrap, mon_wrap, year_wrap;
  logic hour_evt, day_inc_evt, month_inc_evt, year_inc_evt;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int unsigned idx);
    return a == ADDR_W'(idx);
  endfunction

  logic wr_sec, wr_min, wr_day, wr_wday;
  assign wr_sec  = wr_en && hit(wr_addr, A_SEC);
  assign wr_min  = wr_en && hit(wr_addr, A_MIN);
  assign wr_day  = wr_en && hit(wr_addr, A_DAY);
  assign wr_wday = wr_en && hit(wr_addr, A_WDAY);

  always_comb begin
    sec_wrap  = bcd2bin(t_q.sec)  >= 8'd59;
    min_wrap  = bcd2bin(t_q.min)  >= 8'd59;
    hour_wrap = bcd2bin(t_q.hour) >= 8'd23;
    day_wrap  = bcd2bin(t_q.day)  >= month_len(t_q.mon, t_q.year);
    mon_wrap  = bcd2bin(t_q.mon)  >= 8'd12;
    year_wrap = bcd2bin(t_q.year) >= 8'd99;

    sec_zero_evt  = tick && sec_wrap;
    hour_evt      = sec_zero_evt && min_wrap;
    day_inc_evt   = hour_evt && hour_wrap;
    month_inc_evt = day_inc_evt && day_wrap;
    year_inc_evt  = month_inc_evt && mon_wrap;

    n = t_q;
    if (tick)          n.sec  = sec_wrap  ? 8'h00 : bcd_inc(t_q.sec);
    if (sec_zero_evt)  n.min  = min_wrap  ? 8'h00 : bcd_inc(t_q.min);
    if (hour_evt)      n.hour = hour_wrap ? 8'h00 : bcd_inc(t_q.hour);
    if (day_inc_evt) begin
      n.day  = day_wrap ? 8'h01 : bcd_inc(t_q.day);
      n.wday = (t_q.wday >= WDAY_W'(6)) ? '0 : t_q.wday + WDAY_W'(1);
    end
    if (month_inc_evt) n.mon  = mon_wrap  ? 8'h01 : bcd_inc(t_q.mon);
    if (year_inc_evt)  n.year = year_wrap ? 8'h00 : bcd_inc(t_q.year);

    // a write overrides only its own field
    if (wr_en) begin
      if (hit(wr_addr, A_SEC))  n.sec  = wr_data;
      if (hit(wr_addr, A_MIN))  n.min  = wr_data;
      if (hit(wr_addr, A_HOUR)) n.hour = wr_data;
      if (hit(wr_addr, A_DAY))  n.day  = wr_data;
      if (hit(wr_addr, A_MON))  n.mon  = wr_data;
      if (hit(wr_addr, A_YEAR)) n.year = wr_data;
      if (hit(wr_addr, A_WDAY)) n.wday = wr_data[WDAY_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t_q <= '{sec: 8'h00, min: 8'h00, hour: 8'h00, day: 8'h01,
               mon: 8'h01, year: 8'h00, wday: '0};
    end else begin
      t_q <= n;
    end
  end

  assign cur = t_q;
  assign nxt = n;

  p_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !tick && !wr_en |=> $stable(t_q));

  p_sec_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sec_zero_evt && !wr_sec |=> t_q.sec == 8'h00);

  p_min_write_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_min |=> t_q.min == $past(wr_data));

  p_month_day1_r2: assert property (@(posedge clk) disable iff (!rst_n)
    month_inc_evt && !wr_day |=> t_q.day == 8'h01);

  p_wday_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    day_inc_evt && !wr_wday |=>
      t_q.wday == (($past(t_q.wday) >= WDAY_W'(6)) ? WDAY_W'(0) : $past(t_q.wday) + WDAY_W'(1)));

endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int NFLD   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  cal_t              nxt,
  input  logic              sec_zero_evt,
  output logic [7:0]        al_fld [NFLD],
  output logic [NFLD-1:0]   al_en,
  output logic              alarm_flag
);

  logic [7:0]      cmp_val [NFLD];
  logic [NFLD-1:0] fld_match;
  logic            alarm_set, clr_req;

  assign cmp_val[0] = nxt.min;
  assign cmp_val[1] = nxt.hour;
  assign cmp_val[2] = nxt.day;
  assign cmp_val[3] = nxt.mon;
  assign cmp_val[4] = nxt.year;

  for (genvar i = 0; i < NFLD; i++) begin : g_fld
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) al_fld[i] <= 8'h00;
      else if (wr_en && wr_addr == ADDR_W'(A_AL_MIN + i)) al_fld[i] <= wr_data;
    end
    assign fld_match[i] = al_fld[i] == cmp_val[i];
  end

  assign clr_req   = wr_en && wr_addr == ADDR_W'(A_FLAGS) && wr_data[0];
  assign alarm_set = sec_zero_evt && (|al_en) && ((fld_match | ~al_en) == '1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      al_en      <= '0;
      alarm_flag <= 1'b0;
    end else begin
      if (wr_en && wr_addr == ADDR_W'(A_AL_EN)) al_en <= wr_data[NFLD-1:0];
      if (alarm_set)    alarm_flag <= 1'b1;
      else if (clr_req) alarm_flag <= 1'b0;
    end
  end

  p_alarm_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_flag && !clr_req |=> alarm_flag);

  p_alarm_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_flag) |-> $past(sec_zero_evt));

  p_alarm_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_set |=> alarm_flag);

endmodule

// File: rtl/rtc_timer.sv
module rtc_timer
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int TMR_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic [TMR_W-1:0]  period,
  output logic [1:0]        ctrl,
  output logic              timer_flag
);

  logic [TMR_W-1:0] cnt;
  logic             run, wr_ctrl, clr_req, timer_fire;

  assign wr_ctrl    = wr_en && wr_addr == ADDR_W'(A_TM_CTRL);
  assign clr_req    = wr_en && wr_addr == ADDR_W'(A_FLAGS) && wr_data[1];
  assign timer_fire = tick && run && !wr_ctrl && cnt <= TMR_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period     <= '0;
      ctrl       <= '0;
      cnt        <= '0;
      run        <= 1'b0;
      timer_flag <= 1'b0;
    end else begin
      if (wr_en && wr_addr == ADDR_W'(A_TM_PER)) period <= TMR_W'(wr_data);
      if (wr_ctrl) begin
        ctrl <= wr_data[1:0];
        cnt  <= period;
        run  <= wr_data[0] && period != '0;
      end else if (tick && run) begin
        if (timer_fire) begin
          cnt <= period;
          run <= ctrl[1];
        end else begin
          cnt <= cnt - TMR_W'(1);
        end
      end
      if (timer_fire)   timer_flag <= 1'b1;
      else if (clr_req) timer_flag <= 1'b0;
    end
  end

  p_fire_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
    timer_fire |=> timer_flag);

  p_oneshot_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    timer_fire && !ctrl[1] |=> !run);

  p_cnt_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tick && run && !timer_fire && !wr_ctrl |=> cnt == $past(cnt) - TMR_W'(1));

endmodule

// File: rtl/rtc_calendar_top.sv
module rtc_calendar_top
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int TMR_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o,
  output logic              alarm_irq_o,
  output logic              timer_irq_o
);

  localparam int NFLD = 5;

  cal_t             cur, nxt;
  logic             sec_zero_evt;
  logic [7:0]       al_fld [NFLD];
  logic [NFLD-1:0]  al_en;
  logic [TMR_W-1:0] period;
  logic [1:0]       ctrl;

  rtc_chain #(.ADDR_W(ADDR_W)) u_chain (
    .clk, .rst_n, .tick(tick_i), .wr_en(wr_en_i), .wr_addr(wr_addr_i),
    .wr_data(wr_data_i), .cur, .nxt, .sec_zero_evt
  );

  rtc_alarm #(.ADDR_W(ADDR_W), .NFLD(NFLD)) u_alarm (
    .clk, .rst_n, .wr_en(wr_en_i), .wr_addr(wr_addr_i), .wr_data(wr_data_i),
    .nxt, .sec_zero_evt, .al_fld, .al_en, .alarm_flag(alarm_irq_o)
  );

  rtc_timer #(.ADDR_W(ADDR_W), .TMR_W(TMR_W)) u_timer (
    .clk, .rst_n, .tick(tick_i), .wr_en(wr_en_i), .wr_addr(wr_addr_i),
    .wr_data(wr_data_i), .period, .ctrl, .timer_flag(timer_irq_o)
  );

  always_comb begin
    rd_data_o = 8'h00;
    case (rd_addr_i)
      ADDR_W'(A_SEC):     rd_data_o = cur.sec;
      ADDR_W'(A_MIN):     rd_data_o = cur.min;
      ADDR_W'(A_HOUR):    rd_data_o = cur.hour;
      ADDR_W'(A_DAY):     rd_data_o = cur.day;
      ADDR_W'(A_MON):     rd_data_o = cur.mon;
      ADDR_W'(A_YEAR):    rd_data_o = cur.year;
      ADDR_W'(A_WDAY):    rd_data_o = 8'(cur.wday);
      ADDR_W'(A_AL_MIN):  rd_data_o = al_fld[0];
      ADDR_W'(A_AL_HOUR): rd_data_o = al_fld[1];
      ADDR_W'(A_AL_DAY):  rd_data_o = al_fld[2];
      ADDR_W'(A_AL_MON):  rd_data_o = al_fld[3];
      ADDR_W'(A_AL_YEAR): rd_data_o = al_fld[4];
      ADDR_W'(A_AL_EN):   rd_data_o = 8'(al_en);
      ADDR_W'(A_TM_CTRL): rd_data_o = 8'(ctrl);
      ADDR_W'(A_TM_PER):  rd_data_o = 8'(period);
      ADDR_W'(A_FLAGS):   rd_data_o = {6'd0, timer_irq_o, alarm_irq_o};
      default:            rd_data_o = 8'h00;
    endcase
  end

endmodule

// File: tb/tb_rtc_calendar_top.sv
module tb_rtc_calendar_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [3:0] wr_addr_i = '0;
  logic [7:0] wr_data_i = '0;
  logic [3:0] rd_addr_i = '0;
  logic [7:0] rd_data_o;
  logic       alarm_irq_o, timer_irq_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  rtc_calendar_top dut (
    .clk, .rst_n, .tick_i, .wr_en_i, .wr_addr_i, .wr_data_i,
    .rd_addr_i, .rd_data_o, .alarm_irq_o, .timer_irq_o
  );

  // {req, start yr mon day hr min sec wd, expected yr mon day hr min sec wd}
  localparam int NV = 12;
  localparam logic [115:0] VEC [NV] = '{
    {4'd1, 56'h23_01_15_10_20_30_03, 56'h23_01_15_10_20_31_03}, // R1
    {4'd1, 56'h23_01_15_10_20_59_03, 56'h23_01_15_10_21_00_03}, // R1
    {4'd5, 56'h23_01_15_23_59_59_03, 56'h23_01_16_00_00_00_04}, // R5 R1
    {4'd2, 56'h23_04_30_23_59_59_06, 56'h23_05_01_00_00_00_00}, // R2 R5
    {4'd2, 56'h23_02_28_23_59_59_02, 56'h23_03_01_00_00_00_03}, // R2
    {4'd3, 56'h24_02_28_23_59_59_02, 56'h24_02_29_00_00_00_03}, // R3
    {4'd3, 56'h24_02_29_23_59_59_03, 56'h24_03_01_00_00_00_04}, // R3
    {4'd3, 56'h00_02_28_23_59_59_01, 56'h00_02_29_00_00_00_02}, // R3
    {4'd4, 56'h99_12_31_23_59_59_05, 56'h00_01_01_00_00_00_06}, // R4
    {4'd7, 56'h23_06_31_23_59_59_00, 56'h23_07_01_00_00_00_01}, // R7
    {4'd2, 56'h23_01_31_23_59_59_04, 56'h23_02_01_00_00_00_05}, // R2
    {4'd1, 56'h19_09_09_09_59_59_02, 56'h19_09_09_10_00_00_02}  // R1
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic tk(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick_i = 1'b1;
      @(negedge clk);
      tick_i = 1'b0;
    end
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    rd_addr_i = a;
    #1;
    d = rd_data_o;
  endtask

  task automatic load_time(input logic [55:0] t);
    wr(4'd5, t[55:48]); wr(4'd4, t[47:40]); wr(4'd3, t[39:32]);
    wr(4'd2, t[31:24]); wr(4'd1, t[23:16]); wr(4'd0, t[15:8]);
    wr(4'd6, t[7:0]);
  endtask

  task automatic read_time(output logic [55:0] t);
    logic [7:0] b [7];
    rd(4'd5, b[0]); rd(4'd4, b[1]); rd(4'd3, b[2]); rd(4'd2, b[3]);
    rd(4'd1, b[4]); rd(4'd0, b[5]); rd(4'd6, b[6]);
    t = {b[0], b[1], b[2], b[3], b[4], b[5], b[6]};
  endtask

  initial begin
    #400000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [55:0] t;
    logic [7:0]  v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    read_time(t);
    chk("R11 time after reset", 64'(t), 64'h00_01_01_00_00_00_00);
    rd(4'd15, v); chk("R11 flags", 64'(v), 64'h0);
    rd(4'd12, v); chk("R11 alarm enables", 64'(v), 64'h0);
    rd(4'd13, v); chk("R11 timer control", 64'(v), 64'h0);

    // table walk: R1 R2 R3 R4 R5 R7
    for (int k = 0; k < NV; k++) begin
      load_time(VEC[k][111:56]);
      tk(1);
      read_time(t);
      n_chk++;
      if (t !== VEC[k][55:0]) begin
        n_bad++;
        $display("FAIL R%0d vector %0d actual=%h expected=%h",
                 VEC[k][115:112], k, t, VEC[k][55:0]);
      end
    end

    // R1 no change without tick
    load_time(56'h23_01_15_10_20_30_03);
    repeat (5) @(negedge clk);
    read_time(t);
    chk("R1 hold without tick", 64'(t), 64'h23_01_15_10_20_30_03);

    // R6 write while running: count continues from written value
    wr(4'd0, 8'h10);
    tk(1);
    rd(4'd0, v); chk("R6 running after write", 64'(v), 64'h11);

    // R6 same-cycle tick and minute write
    load_time(56'h23_01_15_10_20_59_03);
    @(negedge clk);
    tick_i = 1'b1; wr_en_i = 1'b1; wr_addr_i = 4'd1; wr_data_i = 8'h07;
    @(negedge clk);
    tick_i = 1'b0; wr_en_i = 1'b0;
    read_time(t);
    chk("R6 write wins, others advance", 64'(t), 64'h23_01_15_10_07_00_03);

    // R8 alarm on minute only
    wr(4'd7, 8'h21);
    wr(4'd12, 8'h01);
    load_time(56'h23_01_15_10_20_58_03);
    tk(1);
    rd(4'd15, v); chk("R8 no alarm before second zero", 64'(v[0]), 64'h0);
    tk(1);
    rd(4'd15, v); chk("R8 alarm on match", 64'(v[0]), 64'h1);
    chk("R8 alarm port", 64'(alarm_irq_o), 64'h1);
    tk(3);
    rd(4'd15, v); chk("R8 alarm sticky", 64'(v[0]), 64'h1);
    wr(4'd15, 8'h01);
    rd(4'd15, v); chk("R8 alarm cleared", 64'(v[0]), 64'h0);

    // R8 no enables: no alarm even on a matching minute
    wr(4'd12, 8'h00);
    load_time(56'h23_01_15_10_20_59_03);
    tk(1);
    rd(4'd15, v); chk("R8 no enable no alarm", 64'(v[0]), 64'h0);

    // R8 minute and hour enabled, hour differs
    wr(4'd8, 8'h11);
    wr(4'd12, 8'h03);
    load_time(56'h23_01_15_10_20_59_03);
    tk(1);
    rd(4'd15, v); chk("R8 hour mismatch", 64'(v[0]), 64'h0);
    load_time(56'h23_01_15_11_20_59_03);
    tk(1);
    rd(4'd15, v); chk("R8 two field match", 64'(v[0]), 64'h1);
    wr(4'd15, 8'h01);

    // R8 year only
    wr(4'd11, 8'h24);
    wr(4'd12, 8'h10);
    load_time(56'h24_07_04_05_33_59_01);
    tk(1);
    rd(4'd15, v); chk("R8 year-only match", 64'(v[0]), 64'h1);
    wr(4'd15, 8'h01);
    wr(4'd12, 8'h00);

    // R9 one-shot, period 3
    wr(4'd14, 8'd3);
    wr(4'd13, 8'h01);
    tk(2);
    rd(4'd15, v); chk("R9 not yet at tick 2", 64'(v[1]), 64'h0);
    tk(1);
    rd(4'd15, v); chk("R9 fired at tick 3", 64'(v[1]), 64'h1);
    chk("R9 timer port", 64'(timer_irq_o), 64'h1);
    wr(4'd15, 8'h02);
    tk(5);
    rd(4'd15, v); chk("R9 one-shot stopped", 64'(v[1]), 64'h0);

    // R10 periodic, period 2
    wr(4'd14, 8'd2);
    wr(4'd13, 8'h03);
    tk(1);
    rd(4'd15, v); chk("R10 not yet at tick 1", 64'(v[1]), 64'h0);
    tk(1);
    rd(4'd15, v); chk("R10 first period", 64'(v[1]), 64'h1);
    wr(4'd15, 8'h02);
    tk(1);
    rd(4'd15, v); chk("R10 mid period", 64'(v[1]), 64'h0);
    tk(1);
    rd(4'd15, v); chk("R10 second period", 64'(v[1]), 64'h1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule